// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Encoder

This block is the digital back end of a parallel (flash) analog-to-digital converter. A bank of 2^N−1 ladder comparators delivers a thermometer word in which, ideally, every comparator below the input level reads 1 and every one above reads 0. An extra comparator sitting above the highest ladder tap reports that the input is out of range. The block turns this word into an N-bit binary count of the comparators that are set.

Comparator metastability can flip a single comparator. The result is a lone 0 inside the run of 1s or a lone 1 above it. A plain priority encoder would turn such a flip into a badly wrong code. This block instead finds the top of the run with a three-comparator window. Tap i counts as the transition only when the tap below it and tap i are both 1 and the tap above is 0. An isolated flipped bit therefore never forms a valid transition. The comparator word is registered on entry and the code is registered on exit, so every sample takes the same two cycles to reach the outputs.

Top module: `flash_therm_encoder`

## Requirements
- R1: While `rst_n` is low, `code_o` and `ovr_o` are 0.
- R2: A sample presented before rising edge k appears at the outputs after rising edge k+1. Consecutive samples stream through at one per cycle.
- R3: A clean thermometer word whose lowest k bits are 1 (bit 0 is the lowest ladder tap) gives `code_o` = k.
- R4: An all-zero comparator word with no over-range gives `code_o` = 0.
- R5: An all-ones comparator word with no over-range gives `code_o` = 2^N−1.
- R6: A lone 1 whose lower and upper neighbours are both 0 has no effect on `code_o`. This also holds when it is the only 1 in the word.
- R7: A lone 0 below the top of the run of 1s has no effect on `code_o`.
- R8: When several windows qualify as transitions, the highest one sets `code_o`. A window qualifies when the tap below is 1, the tap itself is 1 and the tap above is 0.
- R9: When the over-range comparator is 1, `ovr_o` is 1 and `code_o` is all ones, whatever the ladder word. Otherwise `ovr_o` is 0.
- R10: The boundary below tap 0 reads as 1 and the boundary above the top tap reads as 0. A word with only bit 0 set therefore gives `code_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 2^N−1 | Ladder comparator outputs, bit 0 is the lowest tap |
| ovr_cmp_i | input | 1 | Comparator above the top ladder tap |
| code_o | output | N | Registered binary code |
| ovr_o | output | 1 | Registered over-range flag |

## Verification
The block holds only the two pipeline stages. A wrong stored value therefore shows at the ports exactly two edges after the sample that caused it, and it is gone again one cycle later. A fault in the window logic shows up as a code that jumps to a bubble position or drops to a lower run, and it shows up only for words that contain bubbles or several runs. The vector table therefore mixes clean words with those patterns. A stream of changing words, checked once per cycle, shows any slip in latency or any mixing of samples between stages.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;
  parameter int unsigned DEF_RES = 4;

  function automatic int unsigned taps_of(input int unsigned res);
    return (1 << res) - 1;
  endfunction
endpackage

// File: rtl/therm_window_detect.sv
module therm_window_detect #(
  parameter int unsigned TAPS = 15
) (
  input  logic [TAPS-1:0] therm_i,
  output logic [TAPS-1:0] edge_o
);
  // boundaries: below tap 0 reads 1, above the top tap reads 0
  logic [TAPS+1:0] ext;
  assign ext = {1'b0, therm_i, 1'b1};

  for (genvar i = 0; i < TAPS; i++) begin : g_win
    logic nand_w;
    assign nand_w    = ~(ext[i] & ext[i+1] & ~ext[i+2]);
    assign edge_o[i] = ~nand_w;
  end
endmodule

// File: rtl/top_index_encoder.sv
module top_index_encoder #(
  parameter int unsigned TAPS = 15,
  parameter int unsigned W    = 4
) (
  input  logic [TAPS-1:0] hit_i,
  output logic [W-1:0]    count_o
);
  // highest set position wins: later iterations override earlier ones
  always_comb begin
    count_o = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (hit_i[i]) count_o = W'(i + 1);
    end
  end
endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder
  import flash_enc_pkg::*;
#(
  parameter int unsigned N    = DEF_RES,
  parameter int unsigned TAPS = taps_of(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] cmp_i,
  input  logic            ovr_cmp_i,
  output logic [N-1:0]    code_o,
  output logic            ovr_o
);
  logic [TAPS-1:0] cmp_q, cmp_d;
  logic            ovr_q, ovr_d;
  logic [TAPS-1:0] edges;
  logic [N-1:0]    raw_code;
  logic [N-1:0]    code_d;
  logic            ovr_out_d;

  // input stage
  always_comb begin
    cmp_d = cmp_i;
    ovr_d = ovr_cmp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      ovr_q <= ovr_d;
    end
  end

  therm_window_detect #(.TAPS(TAPS)) i_win (
    .therm_i (cmp_q),
    .edge_o  (edges)
  );

  top_index_encoder #(.TAPS(TAPS), .W(N)) i_enc (
    .hit_i   (edges),
    .count_o (raw_code)
  );

  // output stage: saturate on over-range
  always_comb begin
    code_d    = ovr_q ? '1 : raw_code;
    ovr_out_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      ovr_o  <= 1'b0;
    end else begin
      code_o <= code_d;
      ovr_o  <= ovr_out_d;
    end
  end
endmodule

// File: rtl/therm_enc_checker.sv
module therm_enc_checker #(
  parameter int unsigned N    = 4,
  parameter int unsigned TAPS = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TAPS-1:0] cmp_i,
  input logic            ovr_cmp_i,
  input logic [N-1:0]    code_o,
  input logic            ovr_o
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R2, R9: flag follows the over-range comparator two edges later
  p_ovr_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (ovr_o == $past(ovr_cmp_i, 2)));

  // R9: over-range saturates the code
  p_ovr_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> (code_o == {N{1'b1}}));

  // R4: all-zero word gives zero code
  p_zero_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd2) && ($past(cmp_i, 2) == '0) && !$past(ovr_cmp_i, 2))
      |-> (code_o == '0));

  // R5: all-ones word gives full-scale code
  p_full_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd2) && (&$past(cmp_i, 2)))
      |-> (code_o == {N{1'b1}}));

  // R1: outputs idle while held in reset
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (code_o == '0 && !ovr_o);
    end
  end
endmodule

bind flash_therm_encoder therm_enc_checker #(.N(N), .TAPS(TAPS)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_i     (cmp_i),
  .ovr_cmp_i (ovr_cmp_i),
  .code_o    (code_o),
  .ovr_o     (ovr_o)
);

// File: tb/test_flash_therm_encoder.sv
module test_flash_therm_encoder;
  localparam int N    = 4;
  localparam int TAPS = 15;
  localparam int NV   = 12;

  // stimulus: bit 15 = over-range comparator, bits 14:0 = ladder
  localparam logic [15:0] STIM [NV] = '{
    16'h0000, 16'h0007, 16'h00FF, 16'h7FFF, 16'h0001, 16'h0023,
    16'h00F7, 16'h0067, 16'hFFFF, 16'h8003, 16'h1000, 16'h3FFF };
  // expected: {ovr, code}
  localparam logic [4:0] EXPV [NV] = '{
    5'h00, 5'h03, 5'h08, 5'h0F, 5'h01, 5'h02,
    5'h08, 5'h07, 5'h1F, 5'h1F, 5'h00, 5'h0E };
  localparam string TAG [NV] = '{
    "R4", "R3", "R3", "R5", "R10", "R6",
    "R7", "R8", "R9", "R9", "R6", "R3" };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [TAPS-1:0] cmp_i;
  logic            ovr_cmp_i;
  logic [N-1:0]    code_o;
  logic            ovr_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_therm_encoder #(.N(N)) i_flash_therm_encoder (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .ovr_cmp_i(ovr_cmp_i),
    .code_o(code_o), .ovr_o(ovr_o));

  task automatic check(input string req, input logic [4:0] exp);
    checks++;
    if ({ovr_o, code_o} !== exp) begin
      errors++;
      $display("FAIL %s: got ovr=%0b code=%0d, expected ovr=%0b code=%0d",
               req, ovr_o, code_o, exp[4], exp[3:0]);
    end
  endtask

  task automatic drive(input logic [15:0] v);
    cmp_i     = v[14:0];
    ovr_cmp_i = v[15];
  endtask

  initial begin
    rst_n = 1'b0;
    drive(16'hFFFF);
    repeat (3) @(negedge clk);
    check("R1", 5'h00);
    rst_n = 1'b1;

    // table walk
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(STIM[k]);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check(TAG[k], EXPV[k]);
    end

    // R2: streaming, one sample per cycle, two-edge latency
    for (int k = 0; k < NV + 2; k++) begin
      @(negedge clk);
      if (k >= 2) check("R2", EXPV[k-2]);
      if (k < NV) drive(STIM[k]);
    end

    // R6: lone 1 in the top tap above an empty ladder
    @(negedge clk); drive(16'h4000);
    repeat (2) @(posedge clk);
    @(negedge clk); check("R6", 5'h00);

    // R7: lone 0 at the lowest tap under a full run
    @(negedge clk); drive(16'h7FFE);
    repeat (2) @(posedge clk);
    @(negedge clk); check("R7", 5'h0F);

    // R1: reset mid-run clears outputs at once
    @(negedge clk); drive(16'h8000);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b0;
    #1 check("R1", 5'h00);
    @(negedge clk); rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule